// File: doc/BRIEF.md
# Banked Nibble Real-Time Clock

This block keeps calendar time in BCD, one decimal digit per 4-bit register, and exposes everything through a 16-address nibble window. A mode register picks which of four banks the lower thirteen addresses reach: the running time and date, the alarm and configuration bank, or one of two 13-nibble scratch RAM blocks. The three top addresses (mode, test and reset control) are visible from every bank.

An external clock-enable `tick` is divided down to one-second steps. The seconds step carries through minutes, hours, day of week, day of month, month and year. Month lengths follow a two-bit leap counter, and hours run in either 24-hour or 12-hour form with a PM flag. Software clears the timer-enable bit to freeze the counters. It can then read or load a coherent time and set the bit again to resume. A latched alarm output compares the minute, hour, weekday and day fields, and any field may be left out of the comparison.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00. The mode, test and reset-control registers read 0, the 12/24 select reads 1 (24-hour), the leap counter reads 0, and all outputs are low.
- R2: Address 0xD is the mode register, 0xE a plain 4-bit test register and 0xF the reset control. All three read and write the same way in every bank. Mode bits [1:0] select the bank (0 time, 1 alarm/config, 2 RAM A, 3 RAM B), bit 2 enables the alarm and bit 3 enables the timer. A read of 0xF returns the two pulse enables in bits [3:2] and 0 in bits [1:0].
- R3: While mode bit 3 is 0, no tick changes any time or date digit.
- R4: While the timer runs, every SUB_DIV-th tick ends a second. A reset-control write with bit 1 set restarts the sub-second count from zero, so SUB_DIV further ticks are needed.
- R5: Bank 0 digit addresses are 0/1 seconds units/tens, 2/3 minutes, 4/5 hours, 6 weekday, 7/8 day, 9/10 month and 11/12 year. Seconds and minutes wrap from 59 to 00 with a carry, and in 24-hour mode hours wrap from 23 to 00.
- R6: A day carry advances the weekday (6 wraps to 0) and the day of month. The day wraps to 01 after 30 days (April, June, September, November), after 31 days (the other months except February), and in February after 29 days when the leap counter (bank 1 address 0xB) is 0 or after 28 days otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00, and every year carry adds 1 (modulo 4) to the leap counter.
- R7: With bank 1 address 0xA bit 0 cleared, hours count 12, 01 … 11. Hours-tens bit 1 is the PM flag and bit 0 the tens digit. 11 to 12 toggles PM, and only the PM-to-AM change carries into the day.
- R8: A bus write to a bank 0 digit loads it whether or not the timer runs. When the write and a count change reach the same digit in one cycle, the written value is kept, and the other digits still follow the count.
- R9: Banks 2 and 3 each hold 13 independent nibbles at addresses 0x0–0xC that keep their contents while time advances.
- R10: Bank 1 addresses 2–8 hold alarm digits for minutes units/tens, hours units/tens, weekday and day units/tens. An alarm digit of 0xF is ignored. With the alarm enabled, the `alarm` output rises one cycle after all other alarm digits equal the time digits, and it stays high after the match ends.
- R11: `alarm` falls after the alarm enable is cleared or after a reset-control write with bit 0 set. That write also sets all seven alarm digits to 0.
- R12: Reset-control bit 2 enables `pulse_16hz`, high for one cycle after each tick. Bit 3 enables `pulse_1hz`, high for one cycle after each second ends.
- R13: `rdata` is loaded with the addressed nibble on the clock edge where `rd` is high and holds that value while `rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Sub-second clock enable, SUB_DIV per second |
| addr | input | 4 | Nibble register address |
| wdata | input | 4 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, loads `rdata` |
| rdata | output | 4 | Registered read data |
| alarm | output | 1 | Latched alarm |
| pulse_16hz | output | 1 | One-cycle pulse per tick when enabled |
| pulse_1hz | output | 1 | One-cycle pulse per second when enabled |

## Verification
A bus write to a bank 0 digit and the carry from the end of a second can fall in the same cycle. The bench makes this happen on purpose. It restarts the sub-second count, issues one tick fewer than SUB_DIV, and then raises the last tick in the same cycle as a write to the seconds units or minutes units. Reading the digits back then shows whether the written digit won on its own while the carry still reached the digits around it. The alarm latch is also checked against a match that disappears while the enable stays set.

// File: rtl/nrtc_pkg.sv
package nrtc_pkg;
  localparam int NUM_TIME = 13;
  localparam int NUM_ALM  = 7;

  typedef logic [NUM_TIME-1:0][3:0] nib_file_t;
  typedef logic [NUM_ALM-1:0][3:0]  alm_file_t;

  typedef enum logic [1:0] {
    BANK_TIME  = 2'd0,
    BANK_CFG   = 2'd1,
    BANK_RAM_A = 2'd2,
    BANK_RAM_B = 2'd3
  } nrtc_bank_e;

  // digit positions inside bank 0 (alarm bank reuses 2..8)
  localparam logic [3:0] A_SEC_U = 4'd0;
  localparam logic [3:0] A_SEC_T = 4'd1;
  localparam logic [3:0] A_MIN_U = 4'd2;
  localparam logic [3:0] A_MIN_T = 4'd3;
  localparam logic [3:0] A_HR_U  = 4'd4;
  localparam logic [3:0] A_HR_T  = 4'd5;
  localparam logic [3:0] A_WDAY  = 4'd6;
  localparam logic [3:0] A_DAY_U = 4'd7;
  localparam logic [3:0] A_DAY_T = 4'd8;
  localparam logic [3:0] A_MON_U = 4'd9;
  localparam logic [3:0] A_MON_T = 4'd10;
  localparam logic [3:0] A_YR_U  = 4'd11;
  localparam logic [3:0] A_YR_T  = 4'd12;
  localparam logic [3:0] A_SEL24 = 4'd10;
  localparam logic [3:0] A_LEAP  = 4'd11;
  localparam logic [3:0] A_MODE  = 4'd13;
  localparam logic [3:0] A_TEST  = 4'd14;
  localparam logic [3:0] A_RSTC  = 4'd15;
  localparam logic [3:0] A_ALM_LO = 4'd2;
  localparam logic [3:0] A_ALM_HI = 4'd8;

  function automatic logic [6:0] bcd_val(input logic [3:0] t, input logic [3:0] u);
    return 7'(t) * 7'd10 + 7'(u);
  endfunction

  function automatic logic [3:0] tens_of(input logic [6:0] v);
    return 4'(v / 7'd10);
  endfunction

  function automatic logic [3:0] units_of(input logic [6:0] v);
    return 4'(v % 7'd10);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic leap0);
    case (m)
      7'd2:                        return leap0 ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/nrtc_prescaler.sv
module nrtc_prescaler #(
  parameter int SUB_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic sec_pulse
);
  localparam int CW = (SUB_DIV > 2) ? $clog2(SUB_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUB_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d     = cnt_q;
    sec_pulse = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (tick && run) begin
      if (cnt_q == LAST) begin
        cnt_d     = '0;
        sec_pulse = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nrtc_timekeeper.sv
module nrtc_timekeeper
  import nrtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       wr_en,
  input  logic [3:0] waddr,
  input  logic [3:0] wdata,
  input  logic       leap_wr,
  input  logic       sel_wr,
  output nib_file_t  time_q,
  output logic [1:0] leap_q,
  output logic       mode24_q
);
  nib_file_t  t_d;
  logic [1:0] leap_d;
  logic       m24_d;
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [6:0] sec_v, min_v, hr_v, h12_v, nh_v, day_v, dim_v, mon_v, yr_v;
  logic [3:0] nh_t;
  logic       pm, npm;

  always_comb begin
    t_d    = time_q;
    leap_d = leap_q;
    m24_d  = mode24_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    sec_v = bcd_val(time_q[A_SEC_T], time_q[A_SEC_U]);
    min_v = bcd_val(time_q[A_MIN_T], time_q[A_MIN_U]);
    hr_v  = bcd_val({2'b00, time_q[A_HR_T][1:0]}, time_q[A_HR_U]);
    h12_v = bcd_val({3'b000, time_q[A_HR_T][0]}, time_q[A_HR_U]);
    pm    = time_q[A_HR_T][1];
    day_v = bcd_val(time_q[A_DAY_T], time_q[A_DAY_U]);
    mon_v = bcd_val(time_q[A_MON_T], time_q[A_MON_U]);
    yr_v  = bcd_val(time_q[A_YR_T], time_q[A_YR_U]);
    dim_v = month_len(mon_v, leap_q == 2'd0);
    nh_v  = '0;
    nh_t  = '0;
    npm   = pm;

    // seconds stage
    if (sec_pulse) begin
      if (sec_v >= 7'd59) begin
        t_d[A_SEC_T] = '0; t_d[A_SEC_U] = '0; c_min = 1'b1;
      end else begin
        t_d[A_SEC_T] = tens_of(sec_v + 7'd1); t_d[A_SEC_U] = units_of(sec_v + 7'd1);
      end
    end
    // minutes stage
    if (c_min) begin
      if (min_v >= 7'd59) begin
        t_d[A_MIN_T] = '0; t_d[A_MIN_U] = '0; c_hr = 1'b1;
      end else begin
        t_d[A_MIN_T] = tens_of(min_v + 7'd1); t_d[A_MIN_U] = units_of(min_v + 7'd1);
      end
    end
    // hours stage, 24h or 12h with PM flag
    if (c_hr) begin
      if (mode24_q) begin
        if (hr_v >= 7'd23) begin
          nh_v = '0; c_day = 1'b1;
        end else begin
          nh_v = hr_v + 7'd1;
        end
        t_d[A_HR_T] = tens_of(nh_v); t_d[A_HR_U] = units_of(nh_v);
      end else begin
        if (h12_v == 7'd11) begin
          nh_v = 7'd12; npm = ~pm; c_day = pm;
        end else if (h12_v >= 7'd12) begin
          nh_v = 7'd1;
        end else begin
          nh_v = h12_v + 7'd1;
        end
        nh_t = tens_of(nh_v);
        t_d[A_HR_T] = {2'b00, npm, nh_t[0]}; t_d[A_HR_U] = units_of(nh_v);
      end
    end
    // day stage
    if (c_day) begin
      t_d[A_WDAY] = (time_q[A_WDAY] >= 4'd6) ? 4'd0 : time_q[A_WDAY] + 4'd1;
      if (day_v >= dim_v) begin
        t_d[A_DAY_T] = '0; t_d[A_DAY_U] = 4'd1; c_mon = 1'b1;
      end else begin
        t_d[A_DAY_T] = tens_of(day_v + 7'd1); t_d[A_DAY_U] = units_of(day_v + 7'd1);
      end
    end
    // month stage
    if (c_mon) begin
      if (mon_v >= 7'd12) begin
        t_d[A_MON_T] = '0; t_d[A_MON_U] = 4'd1; c_yr = 1'b1;
      end else begin
        t_d[A_MON_T] = tens_of(mon_v + 7'd1); t_d[A_MON_U] = units_of(mon_v + 7'd1);
      end
    end
    // year stage and leap counter
    if (c_yr) begin
      leap_d = leap_q + 2'd1;
      if (yr_v >= 7'd99) begin
        t_d[A_YR_T] = '0; t_d[A_YR_U] = '0;
      end else begin
        t_d[A_YR_T] = tens_of(yr_v + 7'd1); t_d[A_YR_U] = units_of(yr_v + 7'd1);
      end
    end
    // bus writes override the counted digit
    for (int i = 0; i < NUM_TIME; i++) begin
      if (wr_en && (waddr == 4'(i))) t_d[i] = wdata;
    end
    if (leap_wr) leap_d = wdata[1:0];
    if (sel_wr)  m24_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q          <= '0;
      time_q[A_DAY_U] <= 4'd1;
      time_q[A_MON_U] <= 4'd1;
      leap_q          <= '0;
      mode24_q        <= 1'b1;
    end else begin
      time_q   <= t_d;
      leap_q   <= leap_d;
      mode24_q <= m24_d;
    end
  end
endmodule

// File: rtl/nrtc_alarm.sv
module nrtc_alarm
  import nrtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] waddr,
  input  logic [3:0] wdata,
  input  logic       clr,
  input  logic       enable,
  input  nib_file_t  time_nib,
  output alm_file_t  alm_q,
  output logic       alarm_q
);
  alm_file_t          alm_d;
  logic [NUM_ALM-1:0] hit;
  logic               alarm_d;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_cmp
    assign hit[i] = (alm_q[i] == 4'hF) || (alm_q[i] == time_nib[i + 2]);
  end

  always_comb begin
    alm_d = alm_q;
    if (clr) begin
      alm_d = '0;
    end else begin
      for (int i = 0; i < NUM_ALM; i++) begin
        if (wr_en && (waddr == 4'(i + 2))) alm_d[i] = wdata;
      end
    end
    alarm_d = enable && !clr && (alarm_q || (&hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      alm_q   <= alm_d;
      alarm_q <= alarm_d;
    end
  end
endmodule

// File: rtl/nrtc_ram.sv
module nrtc_ram #(
  parameter int WORDS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wbank,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic [3:0] rd_a,
  output logic [3:0] rd_b
);
  localparam int NB = 2;
  logic [3:0] rd_bank [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [WORDS-1:0][3:0] mem_q, mem_d;
    always_comb begin
      mem_d = mem_q;
      for (int i = 0; i < WORDS; i++) begin
        if (wr_en && (wbank == 1'(b)) && (addr == 4'(i))) mem_d[i] = wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q <= '0;
      else        mem_q <= mem_d;
    end
    always_comb begin
      rd_bank[b] = '0;
      for (int i = 0; i < WORDS; i++) begin
        if (addr == 4'(i)) rd_bank[b] = mem_q[i];
      end
    end
  end

  assign rd_a = rd_bank[0];
  assign rd_b = rd_bank[1];
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import nrtc_pkg::*;
#(
  parameter int SUB_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [3:0] rdata,
  output logic       alarm,
  output logic       pulse_16hz,
  output logic       pulse_1hz
);
  logic [1:0] rsync_q;
  logic       rst_ni;
  logic [3:0] mode_q, mode_d, test_q, test_d, rdata_q, rdata_d, rd_mux;
  logic       en16_q, en16_d, en1_q, en1_d, p16_q, p1_q;
  logic       common, bank_wr, tk_wr, cfg_wr, alm_wr, ram_wr, rst_wr;
  logic       div_clr, alm_clr, sec_pulse;
  nrtc_bank_e bank;
  nib_file_t  time_nib;
  alm_file_t  alm_nib;
  logic [1:0] leap;
  logic       mode24;
  logic [3:0] ram_a, ram_b;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign bank    = nrtc_bank_e'(mode_q[1:0]);
  assign common  = (addr >= A_MODE);
  assign bank_wr = wr && !common;
  assign tk_wr   = bank_wr && (bank == BANK_TIME);
  assign cfg_wr  = bank_wr && (bank == BANK_CFG);
  assign alm_wr  = cfg_wr && (addr >= A_ALM_LO) && (addr <= A_ALM_HI);
  assign ram_wr  = bank_wr && mode_q[1];
  assign rst_wr  = wr && (addr == A_RSTC);
  assign div_clr = rst_wr && wdata[1];
  assign alm_clr = rst_wr && wdata[0];

  nrtc_prescaler #(.SUB_DIV(SUB_DIV)) u_presc (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .run(mode_q[3]),
    .clr(div_clr), .sec_pulse(sec_pulse)
  );

  nrtc_timekeeper u_time (
    .clk(clk), .rst_n(rst_ni), .sec_pulse(sec_pulse), .wr_en(tk_wr),
    .waddr(addr), .wdata(wdata),
    .leap_wr(cfg_wr && (addr == A_LEAP)), .sel_wr(cfg_wr && (addr == A_SEL24)),
    .time_q(time_nib), .leap_q(leap), .mode24_q(mode24)
  );

  nrtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_ni), .wr_en(alm_wr), .waddr(addr), .wdata(wdata),
    .clr(alm_clr), .enable(mode_q[2]), .time_nib(time_nib),
    .alm_q(alm_nib), .alarm_q(alarm)
  );

  nrtc_ram #(.WORDS(NUM_TIME)) u_ram (
    .clk(clk), .rst_n(rst_ni), .wr_en(ram_wr), .wbank(mode_q[0]),
    .addr(addr), .wdata(wdata), .rd_a(ram_a), .rd_b(ram_b)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == A_MODE) begin
      rd_mux = mode_q;
    end else if (addr == A_TEST) begin
      rd_mux = test_q;
    end else if (addr == A_RSTC) begin
      rd_mux = {en1_q, en16_q, 2'b00};
    end else begin
      unique case (bank)
        BANK_TIME: rd_mux = time_nib[addr];
        BANK_CFG: begin
          if ((addr >= A_ALM_LO) && (addr <= A_ALM_HI)) rd_mux = alm_nib[3'(addr - A_ALM_LO)];
          else if (addr == A_SEL24)                     rd_mux = {3'b000, mode24};
          else if (addr == A_LEAP)                      rd_mux = {2'b00, leap};
        end
        BANK_RAM_A: rd_mux = ram_a;
        BANK_RAM_B: rd_mux = ram_b;
      endcase
    end
  end

  always_comb begin
    mode_d  = (wr && addr == A_MODE) ? wdata : mode_q;
    test_d  = (wr && addr == A_TEST) ? wdata : test_q;
    en16_d  = rst_wr ? wdata[2] : en16_q;
    en1_d   = rst_wr ? wdata[3] : en1_q;
    rdata_d = rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      test_q  <= '0;
      en16_q  <= 1'b0;
      en1_q   <= 1'b0;
      rdata_q <= '0;
      p16_q   <= 1'b0;
      p1_q    <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      test_q  <= test_d;
      en16_q  <= en16_d;
      en1_q   <= en1_d;
      rdata_q <= rdata_d;
      p16_q   <= en16_q && tick;
      p1_q    <= en1_q && sec_pulse;
    end
  end

  assign rdata      = rdata_q;
  assign pulse_16hz = p16_q;
  assign pulse_1hz  = p1_q;
endmodule

// File: rtl/nrtc_checker.sv
module nrtc_checker
  import nrtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic       rd,
  input logic [3:0] rdata,
  input logic       alarm,
  input logic       pulse_1hz,
  input logic [3:0] mode,
  input logic       sec_pulse,
  input nib_file_t  time_nib
);
  // R3: frozen timer and no write leaves every digit alone
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[3] && !wr) |=> $stable(time_nib));

  // R4: second boundaries only while running
  p_sec_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> mode[3]);

  // R10: latched alarm survives while enabled and untouched
  p_alarm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && mode[2] && !wr) |=> alarm);

  // R11: alarm enable cleared drops the alarm
  p_alarm_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[2] |=> !alarm);

  // R12: a one-second pulse implies the timer was running
  p_pulse_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_1hz |-> $past(mode[3]));

  // R13: read data holds without a read strobe
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind nibble_rtc nrtc_checker i_chk (
  .clk(clk), .rst_n(rst_ni), .wr(wr), .rd(rd), .rdata(rdata), .alarm(alarm),
  .pulse_1hz(pulse_1hz), .mode(mode_q), .sec_pulse(sec_pulse), .time_nib(time_nib)
);

// File: tb/test_nibble_rtc.sv
`timescale 1ns/1ps
module test_nibble_rtc;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n, tick, wr, rd;
  logic [3:0] addr, wdata, rdata;
  logic       alarm, pulse_16hz, pulse_1hz;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #2.5 clk = ~clk;

  nibble_rtc #(.SUB_DIV(DIV)) i_nibble_rtc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .alarm(alarm),
    .pulse_16hz(pulse_16hz), .pulse_1hz(pulse_1hz)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input int exp);
    logic [3:0] v;
    rd_reg(a, v);
    chk(req, int'(v), exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // loads time stopped, sets config, restarts divider, then runs in bank 0
  task automatic set_time(input int ss, input int mm, input int ht, input int hu,
                          input int wd, input int dd, input int mo, input int yy,
                          input int lp, input int m24);
    wr_reg(4'hD, 4'h0);
    wr_reg(4'h0, 4'(ss % 10)); wr_reg(4'h1, 4'(ss / 10));
    wr_reg(4'h2, 4'(mm % 10)); wr_reg(4'h3, 4'(mm / 10));
    wr_reg(4'h4, 4'(hu));      wr_reg(4'h5, 4'(ht));
    wr_reg(4'h6, 4'(wd));
    wr_reg(4'h7, 4'(dd % 10)); wr_reg(4'h8, 4'(dd / 10));
    wr_reg(4'h9, 4'(mo % 10)); wr_reg(4'hA, 4'(mo / 10));
    wr_reg(4'hB, 4'(yy % 10)); wr_reg(4'hC, 4'(yy / 10));
    wr_reg(4'hD, 4'h1);
    wr_reg(4'hA, 4'(m24)); wr_reg(4'hB, 4'(lp));
    wr_reg(4'hF, 4'b0010);
    wr_reg(4'hD, 4'h8);
  endtask

  task automatic chk_clock(input string req, input int ss, input int mm, input int ht,
                           input int hu, input int wd, input int dd, input int mo,
                           input int yy);
    chk_reg({req, " sec_u"}, 4'h0, ss % 10); chk_reg({req, " sec_t"}, 4'h1, ss / 10);
    chk_reg({req, " min_u"}, 4'h2, mm % 10); chk_reg({req, " min_t"}, 4'h3, mm / 10);
    chk_reg({req, " hr_u"},  4'h4, hu);      chk_reg({req, " hr_t"},  4'h5, ht);
    chk_reg({req, " wday"},  4'h6, wd);
    chk_reg({req, " day_u"}, 4'h7, dd % 10); chk_reg({req, " day_t"}, 4'h8, dd / 10);
    chk_reg({req, " mon_u"}, 4'h9, mo % 10); chk_reg({req, " mon_t"}, 4'hA, mo / 10);
    chk_reg({req, " yr_u"},  4'hB, yy % 10); chk_reg({req, " yr_t"},  4'hC, yy / 10);
  endtask

  task automatic t_reset;
    chk("R1 alarm", int'(alarm), 0);
    chk("R1 pulse16", int'(pulse_16hz), 0);
    chk("R1 pulse1", int'(pulse_1hz), 0);
    chk_reg("R1 mode", 4'hD, 0);
    chk_reg("R1 test", 4'hE, 0);
    chk_reg("R1 rstc", 4'hF, 0);
    chk_clock("R1", 0, 0, 0, 0, 0, 1, 1, 0);
    wr_reg(4'hD, 4'h1);
    chk_reg("R1 sel24", 4'hA, 1);
    chk_reg("R1 leap", 4'hB, 0);
    wr_reg(4'hD, 4'h0);
  endtask

  task automatic t_freeze_div;
    ticks(3 * DIV);
    chk_reg("R3 frozen sec_u", 4'h0, 0);
    wr_reg(4'hD, 4'h8);
    ticks(DIV - 1);
    chk_reg("R4 before second", 4'h0, 0);
    ticks(1);
    chk_reg("R4 one second", 4'h0, 1);
    ticks(DIV - 1);
    wr_reg(4'hF, 4'b0010);
    ticks(DIV - 1);
    chk_reg("R4 divider restarted", 4'h0, 1);
    ticks(1);
    chk_reg("R4 second after restart", 4'h0, 2);
    wr_reg(4'hD, 4'h0);
    ticks(DIV);
    chk_reg("R3 stopped again", 4'h0, 2);
  endtask

  task automatic t_carry;
    logic [3:0] v;
    set_time(59, 34, 1, 2, 0, 15, 6, 20, 2, 1);
    ticks(DIV);
    chk_clock("R5 minute carry", 0, 35, 1, 2, 0, 15, 6, 20);
    set_time(59, 59, 1, 2, 0, 15, 6, 20, 2, 1);
    ticks(DIV);
    chk_clock("R5 hour carry", 0, 0, 1, 3, 0, 15, 6, 20);
    set_time(59, 59, 2, 3, 6, 28, 2, 3, 0, 1);
    ticks(DIV);
    chk_clock("R5 R6 feb28 leap0", 0, 0, 0, 0, 0, 29, 2, 3);
    set_time(59, 59, 2, 3, 1, 29, 2, 4, 0, 1);
    ticks(DIV);
    chk_clock("R6 feb29 leap0", 0, 0, 0, 0, 2, 1, 3, 4);
    set_time(59, 59, 2, 3, 3, 28, 2, 5, 1, 1);
    ticks(DIV);
    chk_clock("R6 feb28 leap1", 0, 0, 0, 0, 4, 1, 3, 5);
    set_time(59, 59, 2, 3, 4, 30, 4, 5, 1, 1);
    ticks(DIV);
    chk_clock("R6 apr30", 0, 0, 0, 0, 5, 1, 5, 5);
    set_time(59, 59, 2, 3, 4, 30, 5, 5, 1, 1);
    ticks(DIV);
    chk_clock("R6 may30", 0, 0, 0, 0, 5, 31, 5, 5);
    set_time(59, 59, 2, 3, 5, 31, 12, 99, 3, 1);
    ticks(DIV);
    chk_clock("R6 year wrap", 0, 0, 0, 0, 6, 1, 1, 0);
    wr_reg(4'hD, 4'h9);
    rd_reg(4'hB, v);
    chk("R6 leap wraps to 0", int'(v), 0);
    wr_reg(4'hD, 4'h8);
  endtask

  task automatic t_12h;
    set_time(59, 59, 1, 1, 2, 5, 3, 10, 1, 0);
    ticks(DIV);
    chk_clock("R7 11am to 12pm", 0, 0, 3, 2, 2, 5, 3, 10);
    set_time(59, 59, 3, 2, 2, 5, 3, 10, 1, 0);
    ticks(DIV);
    chk_clock("R7 12pm to 1pm", 0, 0, 2, 1, 2, 5, 3, 10);
    set_time(59, 59, 3, 1, 2, 5, 3, 10, 1, 0);
    ticks(DIV);
    chk_clock("R7 11pm to 12am", 0, 0, 1, 2, 3, 6, 3, 10);
  endtask

  task automatic t_collision;
    set_time(59, 20, 1, 0, 1, 9, 9, 9, 1, 1);
    ticks(DIV - 1);
    @(negedge clk); tick = 1'b1; addr = 4'h0; wdata = 4'h5; wr = 1'b1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk_clock("R8 write beats sec carry", 5, 21, 1, 0, 1, 9, 9, 9);
    set_time(59, 20, 1, 0, 1, 9, 9, 9, 1, 1);
    ticks(DIV - 1);
    @(negedge clk); tick = 1'b1; addr = 4'h2; wdata = 4'h7; wr = 1'b1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    chk_clock("R8 write beats min carry", 0, 27, 1, 0, 1, 9, 9, 9);
  endtask

  task automatic t_ram;
    logic [3:0] v;
    wr_reg(4'hD, 4'hA);
    for (int i = 0; i < 13; i++) wr_reg(4'(i), 4'(i + 1));
    wr_reg(4'hD, 4'hB);
    for (int i = 0; i < 13; i++) wr_reg(4'(i), 4'(14 - i));
    ticks(2 * DIV);
    wr_reg(4'hE, 4'h9);
    chk_reg("R9 ram B addr0", 4'h0, 14);
    chk_reg("R9 ram B addr12", 4'hC, 2);
    wr_reg(4'hD, 4'hA);
    chk_reg("R9 ram A addr0", 4'h0, 1);
    chk_reg("R9 ram A addr12", 4'hC, 13);
    chk_reg("R2 mode read in bank2", 4'hD, 10);
    wr_reg(4'hD, 4'h8);
    chk_reg("R2 test read in bank0", 4'hE, 9);
    // R13: held read data
    rd_reg(4'hE, v);
    @(negedge clk); addr = 4'h0;
    wait_cyc(3);
    chk("R13 rdata held", int'(rdata), 9);
  endtask

  task automatic t_alarm;
    set_time(59, 44, 0, 7, 2, 10, 3, 10, 1, 1);
    wr_reg(4'hD, 4'h9);
    wr_reg(4'h2, 4'h5); wr_reg(4'h3, 4'h4);
    wr_reg(4'h4, 4'h7); wr_reg(4'h5, 4'h0);
    wr_reg(4'h6, 4'hF); wr_reg(4'h7, 4'hF); wr_reg(4'h8, 4'hF);
    wr_reg(4'hD, 4'hD);
    wait_cyc(2);
    chk("R10 no match yet", int'(alarm), 0);
    ticks(DIV);
    wait_cyc(1);
    chk("R10 alarm on match", int'(alarm), 1);
    wr_reg(4'h2, 4'h6);
    wait_cyc(2);
    chk("R10 alarm latched", int'(alarm), 1);
    wr_reg(4'hF, 4'b0001);
    wait_cyc(1);
    chk("R11 alarm reset bit", int'(alarm), 0);
    chk_reg("R11 alarm min_u cleared", 4'h2, 0);
    chk_reg("R11 alarm day_t cleared", 4'h8, 0);
    for (int a = 2; a <= 8; a++) wr_reg(4'(a), 4'hF);
    wait_cyc(2);
    chk("R10 all masked", int'(alarm), 1);
    wr_reg(4'hD, 4'h9);
    wait_cyc(1);
    chk("R11 enable cleared", int'(alarm), 0);
  endtask

  task automatic t_pulse;
    set_time(0, 0, 0, 0, 0, 1, 1, 0, 0, 1);
    wr_reg(4'hF, 4'b1100);
    chk_reg("R2 rstc readback", 4'hF, 12);
    for (int i = 0; i < DIV; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R12 pulse16 on tick", int'(pulse_16hz), 1);
      chk("R12 pulse1 on second", int'(pulse_1hz), (i == DIV - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R12 pulse16 one cycle", int'(pulse_16hz), 0);
    chk("R12 pulse1 one cycle", int'(pulse_1hz), 0);
    wr_reg(4'hF, 4'b0000);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R12 pulse16 disabled", int'(pulse_16hz), 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_freeze_div();
    t_carry();
    t_12h();
    t_collision();
    t_ram();
    t_alarm();
    t_pulse();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule